// File: doc/BRIEF.md
# Handshaked Byte Processing Sequencer

This block steps through a byte buffer owned by a memory agent that runs on a different clock. For each byte it raises a read request with an address and waits for the agent to signal that the byte is on the read data bus. It captures the byte and runs it through a transform stage chosen at build time: pass-through, bitwise invert or nibble swap. The transform may take one or several cycles. The sequencer then offers the result with a write address and holds it until the agent reports that the write is complete.

The agent's strobes are slow level toggles from a foreign clock domain. Each one, including the start input, first passes through a two-flop rising-edge detector, which turns a level change into a pulse one clock wide. The total byte count is placed on its own input before start and is latched when the run begins. Addresses are 1-based: byte k of the buffer lives at address k. The run is over once the write address has moved one past the count. The block then raises done and stays finished until reset.

Top module: `byte_seq_top`

## Requirements
- R1: A synchronous active-low reset clears both addresses to 0 and holds rdReq, wrReq and done low.
- R2: Only a rising edge of startIn leaves the idle state. Data-valid edges seen while idle do nothing. Two cycles after startIn rises, rdAddr and wrAddr both read 1, and startIn held high never restarts the run.
- R3: In the wait state with rdReq high, a rising edge of dataValidIn captures rdData for the address on rdAddr. rdAddr then advances by exactly one.
- R4: A data-valid level that stays high causes only one read. Another read needs the input to fall and rise again.
- R5: The captured byte goes through the transform, giving its bitwise inverse in invert mode. wrReq rises exactly 4+LATENCY cycles after dataValidIn rises.
- R6: While wrReq is high, wrAddr and wrData stay constant. Two cycles after writeDoneIn rises, wrReq is low, and one cycle later wrAddr has advanced by one.
- R7: In the wait state, when wrAddr equals the latched count plus one, the block enters the finished state. There done is high, rdReq and wrReq are low, and done stays high with both addresses frozen until reset, whatever the strobes do.
- R8: With a byte count of zero, the block reaches done three cycles after startIn rises, and no read is ever requested.
- R9: byteCount is sampled only when the start edge is accepted. Later changes to it do not alter the run.
- R10: A data-valid edge that arrives in the same cycle as the start edge is dropped. No read takes place until data-valid falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Synchronous active-low reset |
| startIn | input | 1 | Start level from the agent; its rising edge begins a run |
| dataValidIn | input | 1 | Agent's read-data-ready level |
| writeDoneIn | input | 1 | Agent's write-complete level |
| byteCount | input | ADDR_W | Number of bytes in the buffer |
| rdData | input | DATA_W | Byte returned by the agent |
| rdAddr | output | ADDR_W | Address of the byte requested |
| rdReq | output | 1 | High while a byte is being requested |
| wrAddr | output | ADDR_W | Address of the result being written |
| wrData | output | DATA_W | Transformed byte to write |
| wrReq | output | 1 | High while a write is pending |
| done | output | 1 | High once the whole buffer has been written |

## Verification
Because all three edge detectors have the same latency, a start edge and a data-valid edge that rise together reach the control in the same cycle. In that cycle the control is still idle and can act only on start. The bench provokes this by raising startIn and dataValidIn on the same clock. It then checks that the read address stays at 1 with the read request still open and no write ever offered, and that a fresh low-to-high toggle of data-valid is what finally moves the run forward. A second collision is the finish test against a pending read. The bench checks that a buffer's last write leads straight to done with no spurious read request in between.

// File: rtl/byte_seq_pkg.sv
package byte_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_UPD_RD,
    ST_PROC,
    ST_WRITE,
    ST_UPD_WR,
    ST_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    XF_PASS,
    XF_INVERT,
    XF_NIBSWAP
  } xform_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic capByte;
    logic bumpRd;
    logic procRun;
    logic bumpWr;
  } seq_strobe_t;

endpackage

// File: rtl/seq_rise_det.sv
module seq_rise_det (
  input  logic clk,
  input  logic rstN,
  input  logic levelIn,
  output logic pulseOut
);
  logic stageA;
  logic stageB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageA <= 1'b0;
      stageB <= 1'b0;
    end else begin
      stageA <= levelIn;
      stageB <= stageA;
    end
  end

  assign pulseOut = stageA & ~stageB;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import byte_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        validPulse,
  input  logic        wdonePulse,
  input  logic        procDone,
  input  logic        atEnd,
  output seq_strobe_t strobe,
  output logic        rdReq,
  output logic        wrReq,
  output logic        done
);
  seq_state_e stateQ;
  seq_state_e stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.loadStart = 1'b1;
          stateD = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (atEnd)           stateD = ST_FIN;
        else if (validPulse) stateD = ST_READ;
      end
      ST_READ: begin
        strobe.capByte = 1'b1;
        stateD = ST_UPD_RD;
      end
      ST_UPD_RD: begin
        strobe.bumpRd = 1'b1;
        stateD = ST_PROC;
      end
      ST_PROC: begin
        strobe.procRun = 1'b1;
        if (procDone) stateD = ST_WRITE;
      end
      ST_WRITE: begin
        if (wdonePulse) stateD = ST_UPD_WR;
      end
      ST_UPD_WR: begin
        strobe.bumpWr = 1'b1;
        stateD = ST_WAIT;
      end
      ST_FIN: stateD = ST_FIN;
      default: stateD = ST_IDLE;
    endcase
  end

  assign rdReq = (stateQ == ST_WAIT) && !atEnd;
  assign wrReq = (stateQ == ST_WRITE);
  assign done  = (stateQ == ST_FIN);
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import byte_seq_pkg::*;
#(
  parameter int     ADDR_W  = 32,
  parameter int     DATA_W  = 8,
  parameter xform_e XFORM   = XF_PASS,
  parameter int     LATENCY = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [ADDR_W-1:0] byteCount,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              procDone,
  output logic              atEnd
);
  localparam int CNT_W  = (LATENCY > 1) ? $clog2(LATENCY + 1) : 1;
  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] rdAddrQ;
  logic [ADDR_W-1:0] wrAddrQ;
  logic [ADDR_W-1:0] countQ;
  logic [DATA_W-1:0] byteQ;
  logic [CNT_W-1:0]  procCnt;
  logic [DATA_W-1:0] xformOut;

  generate
    if (XFORM == XF_INVERT) begin : g_inv
      assign xformOut = ~byteQ;
    end else if (XFORM == XF_NIBSWAP) begin : g_swap
      assign xformOut = {byteQ[HALF_W-1:0], byteQ[DATA_W-1:HALF_W]};
    end else begin : g_pass
      assign xformOut = byteQ;
    end
  endgenerate

  assign procDone = strobe.procRun && (procCnt == CNT_W'(LATENCY - 1));
  assign atEnd    = {1'b0, wrAddrQ} == ({1'b0, countQ} + {{ADDR_W{1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddrQ <= '0;
      wrAddrQ <= '0;
      countQ  <= '0;
      byteQ   <= '0;
      procCnt <= '0;
    end else begin
      if (strobe.loadStart) begin
        rdAddrQ <= ADDR_W'(1);
        wrAddrQ <= ADDR_W'(1);
        countQ  <= byteCount;
      end
      if (strobe.capByte) byteQ   <= rdData;
      if (strobe.bumpRd)  rdAddrQ <= rdAddrQ + ADDR_W'(1);
      if (strobe.bumpWr)  wrAddrQ <= wrAddrQ + ADDR_W'(1);
      if (strobe.procRun) begin
        if (procDone) begin
          byteQ   <= xformOut;
          procCnt <= '0;
        end else begin
          procCnt <= procCnt + CNT_W'(1);
        end
      end else begin
        procCnt <= '0;
      end
    end
  end

  assign rdAddr = rdAddrQ;
  assign wrAddr = wrAddrQ;
  assign wrData = byteQ;
endmodule

// File: rtl/byte_seq_top.sv
module byte_seq_top
  import byte_seq_pkg::*;
#(
  parameter int     ADDR_W  = 32,
  parameter int     DATA_W  = 8,
  parameter xform_e XFORM   = XF_PASS,
  parameter int     LATENCY = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              dataValidIn,
  input  logic              writeDoneIn,
  input  logic [ADDR_W-1:0] byteCount,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrReq,
  output logic              done
);
  localparam int N_STROBES = 3;

  logic [N_STROBES-1:0] levels;
  logic [N_STROBES-1:0] pulses;
  seq_strobe_t          strobe;
  logic                 procDone;
  logic                 atEnd;

  assign levels = {writeDoneIn, dataValidIn, startIn};

  generate
    for (genvar g = 0; g < N_STROBES; g++) begin : g_edge
      seq_rise_det u_det (
        .clk     (clk),
        .rstN    (rstN),
        .levelIn (levels[g]),
        .pulseOut(pulses[g])
      );
    end
  endgenerate

  seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(pulses[0]),
    .validPulse(pulses[1]),
    .wdonePulse(pulses[2]),
    .procDone  (procDone),
    .atEnd     (atEnd),
    .strobe    (strobe),
    .rdReq     (rdReq),
    .wrReq     (wrReq),
    .done      (done)
  );

  seq_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .XFORM  (XFORM),
    .LATENCY(LATENCY)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .byteCount(byteCount),
    .rdData   (rdData),
    .rdAddr   (rdAddr),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .procDone (procDone),
    .atEnd    (atEnd)
  );
endmodule

// File: rtl/byte_seq_chk.sv
module byte_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReq,
  input logic              wrReq,
  input logic              done,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData
);
  // R1
  excl_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdReq, wrReq, done}));

  // R3
  rd_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdAddr) |-> (rdAddr == $past(rdAddr) + ADDR_W'(1)) || (rdAddr == ADDR_W'(1)));

  // R5
  wr_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrReq) |-> (rdAddr == wrAddr + ADDR_W'(1)));

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> $stable(wrAddr) && $stable(wrData));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done && $stable(rdAddr) && $stable(wrAddr));

  // R7
  done_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rdAddr == wrAddr) && (wrAddr != '0));
endmodule

bind byte_seq_top byte_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .rdReq (rdReq),
  .wrReq (wrReq),
  .done  (done),
  .rdAddr(rdAddr),
  .wrAddr(wrAddr),
  .wrData(wrData)
);

// File: tb/sim_byte_seq_top.sv
`timescale 1ns/1ps
module sim_byte_seq_top;
  import byte_seq_pkg::*;

  localparam int AW  = 32;
  localparam int DW  = 8;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startIn = 1'b0;
  logic          dataValidIn = 1'b0;
  logic          writeDoneIn = 1'b0;
  logic [AW-1:0] byteCount = '0;
  logic [DW-1:0] rdData;
  logic [AW-1:0] rdAddr;
  logic          rdReq;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic          wrReq;
  logic          done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return DW'((a * 37 + 11) & 32'hFF);
  endfunction

  assign rdData = pat(rdAddr);

  byte_seq_top #(.ADDR_W(AW), .DATA_W(DW), .XFORM(XF_INVERT), .LATENCY(LAT)) u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .dataValidIn(dataValidIn),
    .writeDoneIn(writeDoneIn), .byteCount(byteCount), .rdData(rdData),
    .rdAddr(rdAddr), .rdReq(rdReq), .wrAddr(wrAddr), .wrData(wrData),
    .wrReq(wrReq), .done(done)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !ended) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  // reset, idle checks, start; returns with startIn high
  task automatic startRun(input int count);
    startIn = 1'b0; dataValidIn = 1'b0; writeDoneIn = 1'b0;
    rstN = 1'b0; tick(); tick(); rstN = 1'b1; tick();
    // R1 reset state
    check(rdAddr == 0 && wrAddr == 0, "R1 addr", rdAddr, 0);
    check({rdReq, wrReq, done} == 3'b000, "R1 flags", {rdReq, wrReq, done}, 0);
    byteCount = AW'(count);
    // R2 data-valid while idle does nothing
    dataValidIn = 1'b1; tick(); tick(); dataValidIn = 1'b0; tick(); tick();
    check(rdReq == 0 && rdAddr == 0, "R2 idle", rdAddr, 0);
    startIn = 1'b1; tick(); tick();
    check(rdAddr == 1 && wrAddr == 1, "R2 start", wrAddr, 1);
    check(rdReq == (count != 0), "R2 rdReq", rdReq, count != 0);
    byteCount = AW'(999); // R9 change after start
  endtask

  task automatic agentRun(input int count);
    int n;
    for (int i = 1; i <= count; i++) begin
      n = 0;
      while (!rdReq && n < 50) begin tick(); n++; end
      check(rdReq == 1 && rdAddr == AW'(i), "R3 rd addr", rdAddr, i);
      dataValidIn = 1'b0; tick(); dataValidIn = 1'b1;
      n = 0;
      do begin tick(); n++; end while (!wrReq && n < 50);
      check(n == 4 + LAT, "R5 latency", n, 4 + LAT);
      check(rdAddr == AW'(i + 1), "R3 rd step", rdAddr, i + 1);
      check(wrAddr == AW'(i), "R6 wr addr", wrAddr, i);
      check(wrData == ~pat(AW'(i)), "R5 invert", wrData, ~pat(AW'(i)));
      for (int k = 0; k < 3; k++) begin
        tick();
        check(wrReq && wrAddr == AW'(i) && wrData == ~pat(AW'(i)), "R6 hold", wrAddr, i);
      end
      writeDoneIn = 1'b1; tick(); tick();
      check(wrReq == 0, "R6 release", wrReq, 0);
      tick();
      check(wrAddr == AW'(i + 1), "R6 wr step", wrAddr, i + 1);
      if (i < count) begin
        for (int k = 0; k < 4; k++) begin
          check(rdReq && rdAddr == AW'(i + 1), "R4 held valid", rdAddr, i + 1);
          tick();
        end
      end else begin
        check(rdReq == 0, "R7 no read at end", rdReq, 0);
        tick();
        check(done == 1, "R7 done", done, 1);
        check(rdAddr == AW'(count + 1) && wrAddr == AW'(count + 1), "R9 count kept", wrAddr, count + 1);
      end
      writeDoneIn = 1'b0;
    end
    dataValidIn = 1'b0;
  endtask

  task automatic afterDone(input int count);
    startIn = 1'b0; tick(); startIn = 1'b1;
    dataValidIn = 1'b1; writeDoneIn = 1'b1; tick(); tick();
    dataValidIn = 1'b0; writeDoneIn = 1'b0; tick(); tick();
    check(done && !rdReq && !wrReq, "R7 sticky", done, 1);
    check(wrAddr == AW'(count + 1), "R7 frozen", wrAddr, count + 1);
  endtask

  initial begin
    tick();
    // R8 zero count
    startRun(0);
    check(done == 0, "R8 not yet", done, 0);
    tick();
    check(done == 1 && rdAddr == 1, "R8 empty done", rdAddr, 1);
    afterDone(0);

    for (int c = 1; c <= 6; c++) begin
      startRun(c);
      agentRun(c);
      afterDone(c);
    end

    // R10 start and data-valid rising together
    startIn = 1'b0; dataValidIn = 1'b0; writeDoneIn = 1'b0;
    rstN = 1'b0; tick(); tick(); rstN = 1'b1; tick();
    byteCount = AW'(3);
    startIn = 1'b1; dataValidIn = 1'b1;
    for (int k = 0; k < 6; k++) tick();
    check(rdAddr == 1 && rdReq && !wrReq, "R10 dropped", rdAddr, 1);
    agentRun(3);

    finishRun();
  end
endmodule